// File: doc/BRIEF.md
# Interrupt Flag and Mask Controller

This block gathers the event signals of a network interface peripheral into one 8-bit flag register. A second 8-bit register holds one enable per source and a global enable. The block drives a single active-low interrupt line meant for a host that reacts to falling edges. Transient events (receive error, transmit error, transmit done, DMA done) latch into their flag bits whether or not they are enabled, so software can poll them. Two flags are read-only levels. The link-change flag follows a PHY-side link flag qualified by a PHY-side link interrupt enable. The packet-pending flag is set while a pending-packet count is nonzero.

The host reaches both registers through one operation port, issued for one cycle. The operations are a whole-register write, a bit-set with a mask and a bit-clear with a mask. A bit-clear touches only the bits named in the mask. A hardware event on a bit in the same cycle always wins over the host operation, so no event is lost. Both registers are always visible on read ports.

The output is produced by a three-state machine that works from the two registered values. ST_QUIET means no enabled flag is pending. ST_BLOCKED means an enabled flag is pending but the global enable is off. ST_ASSERT means an enabled flag is pending and the global enable is on, and only in this state is the line low. All transitions are direct and depend only on the pending and global conditions. T_PEND_ON goes from ST_QUIET to ST_BLOCKED or ST_ASSERT. T_GLOB_OFF goes from ST_ASSERT to ST_BLOCKED. T_GLOB_ON goes from ST_BLOCKED to ST_ASSERT, which produces a new falling edge. T_PEND_OFF goes from ST_BLOCKED or ST_ASSERT to ST_QUIET. The line is a register that is loaded together with the state, so it changes one clock after the registers change.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, flags_rd and enables_rd read 8'h00 and irq_n is 1.
- R2: A one-cycle pulse on ev_rx_err, ev_tx_err, ev_tx_done or ev_dma_done sets flag bit 0, 1, 3 or 5 respectively, visible one clock later. This happens regardless of any enable bit.
- R3: Flag bit 4 is the registered value of phy_link_flag AND phy_link_ie. Host operations on the flag register do not change it.
- R4: Flag bit 6 is the registered value of (pkt_count != 0). Host operations on the flag register do not change it.
- R5: host_op encodes 2'b00 none, 2'b01 write, 2'b10 bit-set (OR with host_data) and 2'b11 bit-clear (AND with NOT host_data). host_sel 0 selects the flag register and 1 selects the enable register. A bit-clear leaves every bit not in the mask unchanged.
- R6: When a hardware event and a host operation that would clear the same flag bit fall in one cycle, the flag ends set.
- R7: irq_n goes low one clock after the registers hold some flag bit whose enable bit (same position) is set while enable bit 7 (global) is set. Otherwise it is high.
- R8: Clearing enable bit 7 returns irq_n high one clock later. Setting it again while an enabled flag is still pending drives irq_n low one clock later, giving a new falling edge.
- R9: irq_n stays low until every enabled pending flag is either cleared or masked by clearing its enable. Masking does not clear the flag.
- R10: Flag bits 2 and 7 and enable bit 2 always read 0, even after a write of 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_op | input | 2 | Host operation: none, write, bit-set, bit-clear |
| host_sel | input | 1 | Target register: 0 flags, 1 enables |
| host_data | input | 8 | Write value or bit mask |
| ev_rx_err | input | 1 | Receive error event pulse |
| ev_tx_err | input | 1 | Transmit error event pulse |
| ev_tx_done | input | 1 | Transmit done event pulse |
| ev_dma_done | input | 1 | DMA done event pulse |
| pkt_count | input | 8 | Number of packets pending in the receive buffer |
| phy_link_flag | input | 1 | PHY-side link change flag |
| phy_link_ie | input | 1 | PHY-side link interrupt enable |
| flags_rd | output | 8 | Current flag register |
| enables_rd | output | 8 | Current enable register, bit 7 global |
| irq_n | output | 1 | Active-low interrupt line |

## Verification
On every cycle, the assertions check the following:
- An event bit is set in the flag register one clock after its pulse, even when a host clear hits that bit in the same cycle.
- A bit-clear without an event changes only the masked bits.
- The link flag tracks its qualified PHY level.
- A falling edge on irq_n is always preceded by a pending enabled flag with the global enable on.
- The line rises whenever the global enable is off or nothing is pending.

Only the directed scenarios can show the following:
- The exact write, set and clear results for chosen values.
- The fresh falling edge when the global enable is restored.
- The release of the line by masking while the flag stays readable.
- The reads of the reserved bits.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int REG_W    = 8;
    localparam int B_RXERR  = 0;
    localparam int B_TXERR  = 1;
    localparam int B_TXDONE = 3;
    localparam int B_LINK   = 4;
    localparam int B_DMA    = 5;
    localparam int B_PKT    = 6;
    localparam int B_GLOBAL = 7;

    localparam logic [REG_W-1:0] LATCH_MASK  = (REG_W'(1) << B_RXERR) | (REG_W'(1) << B_TXERR)
                                             | (REG_W'(1) << B_TXDONE) | (REG_W'(1) << B_DMA);
    localparam logic [REG_W-1:0] GLOBAL_MASK = REG_W'(1) << B_GLOBAL;
    localparam logic [REG_W-1:0] EN_MASK     = LATCH_MASK | (REG_W'(1) << B_LINK)
                                             | (REG_W'(1) << B_PKT) | GLOBAL_MASK;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLR   = 2'b11
    } host_op_e;

    typedef enum logic [1:0] {
        ST_QUIET   = 2'b00,
        ST_BLOCKED = 2'b01,
        ST_ASSERT  = 2'b10
    } irq_state_e;

    function automatic logic [REG_W-1:0] apply_op(input host_op_e op,
                                                  input logic [REG_W-1:0] cur,
                                                  input logic [REG_W-1:0] data);
        logic [REG_W-1:0] res;
        unique case (op)
            OP_WRITE: res = data;
            OP_SET:   res = cur | data;
            OP_CLR:   res = cur & ~data;
            default:  res = cur;
        endcase
        return res;
    endfunction
endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  host_op_e         op,
    input  logic             sel_flags,
    input  logic [REG_W-1:0] host_data,
    input  logic             ev_rx_err,
    input  logic             ev_tx_err,
    input  logic             ev_tx_done,
    input  logic             ev_dma_done,
    input  logic [CNT_W-1:0] pkt_count,
    input  logic             phy_link_flag,
    input  logic             phy_link_ie,
    output logic [REG_W-1:0] flag_q
);
    logic [REG_W-1:0] ev_vec;
    logic [REG_W-1:0] host_next;
    logic [REG_W-1:0] flag_d;
    logic             link_lvl;
    logic             pkt_nz;
    logic             host_we;

    always_comb begin
        ev_vec           = '0;
        ev_vec[B_RXERR]  = ev_rx_err;
        ev_vec[B_TXERR]  = ev_tx_err;
        ev_vec[B_TXDONE] = ev_tx_done;
        ev_vec[B_DMA]    = ev_dma_done;
    end

    assign host_we   = sel_flags && (op != OP_NONE);
    assign host_next = host_we ? apply_op(op, flag_q, host_data) : flag_q;
    assign link_lvl  = phy_link_flag & phy_link_ie;
    assign pkt_nz    = |pkt_count;

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (LATCH_MASK[b]) begin : g_latch
            assign flag_d[b] = host_next[b] | ev_vec[b];
        end else if (b == B_LINK) begin : g_link
            assign flag_d[b] = link_lvl;
        end else if (b == B_PKT) begin : g_pkt
            assign flag_d[b] = pkt_nz;
        end else begin : g_rsvd
            assign flag_d[b] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vec != '0) |=> ((flag_q & $past(ev_vec)) == $past(ev_vec)));

    assert_clear_only_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && op == OP_CLR && ev_vec == '0)
        |=> ((flag_q & LATCH_MASK) == ($past(flag_q) & ~$past(host_data) & LATCH_MASK)));

    assert_link_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_link_flag && phy_link_ie) |=> flag_q[B_LINK]);

    assert_link_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(phy_link_flag && phy_link_ie) |=> !flag_q[B_LINK]);
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  host_op_e         op,
    input  logic             sel_en,
    input  logic [REG_W-1:0] host_data,
    output logic [REG_W-1:0] en_q
);
    logic host_we;
    assign host_we = sel_en && (op != OP_NONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q <= '0;
        else if (host_we) en_q <= apply_op(op, en_q, host_data) & EN_MASK;
    end
endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] flags,
    input  logic [REG_W-1:0] enables,
    output logic             irq_n
);
    irq_state_e state_q;
    irq_state_e nxt;
    logic       pend;
    logic       glob;

    assign pend = |(flags & enables & ~GLOBAL_MASK);
    assign glob = |(enables & GLOBAL_MASK);

    always_comb begin
        unique case (state_q)
            ST_QUIET: begin
                if (pend) nxt = glob ? ST_ASSERT : ST_BLOCKED;
                else      nxt = ST_QUIET;
            end
            ST_BLOCKED: begin
                if (!pend)     nxt = ST_QUIET;
                else if (glob) nxt = ST_ASSERT;
                else           nxt = ST_BLOCKED;
            end
            ST_ASSERT: begin
                if (!pend)      nxt = ST_QUIET;
                else if (!glob) nxt = ST_BLOCKED;
                else            nxt = ST_ASSERT;
            end
            default: nxt = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= (nxt != ST_ASSERT);
    end

    assert_fall_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(glob) && $past(pend)));

    assert_global_off_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !glob |=> irq_n);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> irq_n);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       host_op,
    input  logic             host_sel,
    input  logic [REG_W-1:0] host_data,
    input  logic             ev_rx_err,
    input  logic             ev_tx_err,
    input  logic             ev_tx_done,
    input  logic             ev_dma_done,
    input  logic [CNT_W-1:0] pkt_count,
    input  logic             phy_link_flag,
    input  logic             phy_link_ie,
    output logic [REG_W-1:0] flags_rd,
    output logic [REG_W-1:0] enables_rd,
    output logic             irq_n
);
    host_op_e op;
    assign op = host_op_e'(host_op);

    irq_flag_reg #(.CNT_W(CNT_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .op(op), .sel_flags(!host_sel),
        .host_data(host_data), .ev_rx_err(ev_rx_err), .ev_tx_err(ev_tx_err),
        .ev_tx_done(ev_tx_done), .ev_dma_done(ev_dma_done), .pkt_count(pkt_count),
        .phy_link_flag(phy_link_flag), .phy_link_ie(phy_link_ie), .flag_q(flags_rd)
    );

    irq_enable_reg u_enables (
        .clk(clk), .rst_n(rst_n), .op(op), .sel_en(host_sel),
        .host_data(host_data), .en_q(enables_rd)
    );

    irq_out_fsm u_out (
        .clk(clk), .rst_n(rst_n), .flags(flags_rd), .enables(enables_rd), .irq_n(irq_n)
    );
endmodule

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_op = 2'b00;
    logic       host_sel = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       ev_rx_err = 1'b0, ev_tx_err = 1'b0, ev_tx_done = 1'b0, ev_dma_done = 1'b0;
    logic [7:0] pkt_count = 8'h00;
    logic       phy_link_flag = 1'b0, phy_link_ie = 1'b0;
    logic [7:0] flags_rd, enables_rd;
    logic       irq_n;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    localparam logic [1:0] WR = 2'b01, BS = 2'b10, BC = 2'b11;

    always #4 clk = ~clk;

    irq_flag_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .host_op(host_op), .host_sel(host_sel),
        .host_data(host_data), .ev_rx_err(ev_rx_err), .ev_tx_err(ev_tx_err),
        .ev_tx_done(ev_tx_done), .ev_dma_done(ev_dma_done), .pkt_count(pkt_count),
        .phy_link_flag(phy_link_flag), .phy_link_ie(phy_link_ie),
        .flags_rd(flags_rd), .enables_rd(enables_rd), .irq_n(irq_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic hw(input logic [1:0] op, input logic sel, input logic [7:0] d);
        host_op = op; host_sel = sel; host_data = d;
        step();
        host_op = 2'b00; host_data = 8'h00;
    endtask

    task automatic pulse(input int idx);
        case (idx)
            0: ev_rx_err = 1'b1;
            1: ev_tx_err = 1'b1;
            3: ev_tx_done = 1'b1;
            default: ev_dma_done = 1'b1;
        endcase
        step();
        ev_rx_err = 1'b0; ev_tx_err = 1'b0; ev_tx_done = 1'b0; ev_dma_done = 1'b0;
    endtask

    task automatic clean();
        hw(WR, 1'b1, 8'h00);
        hw(WR, 1'b0, 8'h00);
        step();
    endtask

    task automatic t_reset();
        check("R1 flags", flags_rd, 8'h00);
        check("R1 enables", enables_rd, 8'h00);
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_latch();
        pulse(0);
        check("R2 rx_err bit0", flags_rd, 8'h01);
        pulse(1); pulse(3); pulse(5);
        check("R2 all latched", flags_rd, 8'h2B);
        step();
        check("R2 no irq while disabled", {7'd0, irq_n}, 8'h01);
        hw(BC, 1'b0, 8'hFF);
        check("R2 cleared", flags_rd, 8'h00);
    endtask

    task automatic t_link();
        phy_link_flag = 1'b1; phy_link_ie = 1'b0;
        step(); step();
        check("R3 gated off", flags_rd & 8'h10, 8'h00);
        phy_link_ie = 1'b1;
        step();
        check("R3 link set", flags_rd & 8'h10, 8'h10);
        hw(BC, 1'b0, 8'h10);
        check("R3 clear ignored", flags_rd & 8'h10, 8'h10);
        phy_link_flag = 1'b0;
        step();
        check("R3 link follows", flags_rd & 8'h10, 8'h00);
        phy_link_ie = 1'b0;
    endtask

    task automatic t_pkt();
        pkt_count = 8'd3;
        step();
        check("R4 pkt set", flags_rd, 8'h40);
        hw(BC, 1'b0, 8'h40);
        check("R4 clear ignored", flags_rd, 8'h40);
        hw(WR, 1'b0, 8'h00);
        check("R4 write ignored", flags_rd, 8'h40);
        pkt_count = 8'd0;
        step();
        check("R4 pkt gone", flags_rd, 8'h00);
    endtask

    task automatic t_bitops();
        hw(WR, 1'b1, 8'h21);
        check("R5 en write", enables_rd, 8'h21);
        hw(BS, 1'b1, 8'h0A);
        check("R5 en set", enables_rd, 8'h2B);
        hw(BC, 1'b1, 8'h01);
        check("R5 en clear", enables_rd, 8'h2A);
        check("R5 flags untouched by en ops", flags_rd, 8'h00);
        hw(WR, 1'b1, 8'h00);
        pulse(0); pulse(1);
        hw(BC, 1'b0, 8'h01);
        check("R5 flag clear mask only", flags_rd, 8'h02);
        hw(BS, 1'b0, 8'h08);
        check("R5 flag set", flags_rd, 8'h0A);
        hw(WR, 1'b0, 8'h20);
        check("R5 flag write", flags_rd, 8'h20);
        hw(BC, 1'b0, 8'hFF);
        check("R5 flag all clear", flags_rd, 8'h00);
    endtask

    task automatic t_race();
        pulse(5);
        ev_dma_done = 1'b1; ev_rx_err = 1'b1;
        hw(BC, 1'b0, 8'h21);
        ev_dma_done = 1'b0; ev_rx_err = 1'b0;
        check("R6 set wins over clear", flags_rd, 8'h21);
        ev_tx_err = 1'b1;
        hw(WR, 1'b0, 8'h00);
        ev_tx_err = 1'b0;
        check("R6 set wins over write", flags_rd, 8'h02);
        hw(BC, 1'b0, 8'hFF);
    endtask

    task automatic t_irq();
        hw(WR, 1'b1, 8'h08);
        pulse(3);
        step();
        check("R7 no global no irq", {7'd0, irq_n}, 8'h01);
        hw(BS, 1'b1, 8'h80);
        check("R7 one clock latency", {7'd0, irq_n}, 8'h01);
        step();
        check("R7 irq low", {7'd0, irq_n}, 8'h00);
        hw(BC, 1'b0, 8'h08);
        step();
        check("R7 irq high after clear", {7'd0, irq_n}, 8'h01);
        clean();
    endtask

    task automatic t_global();
        hw(WR, 1'b1, 8'h88);
        pulse(3);
        step();
        check("R8 asserted", {7'd0, irq_n}, 8'h00);
        hw(BC, 1'b1, 8'h80);
        step();
        check("R8 global off high", {7'd0, irq_n}, 8'h01);
        hw(BS, 1'b1, 8'h80);
        check("R8 still high before edge", {7'd0, irq_n}, 8'h01);
        step();
        check("R8 fresh falling edge", {7'd0, irq_n}, 8'h00);
        clean();
    endtask

    task automatic t_mask();
        hw(WR, 1'b1, 8'h89);
        pulse(0); pulse(3);
        step();
        check("R9 low with two", {7'd0, irq_n}, 8'h00);
        hw(BC, 1'b0, 8'h08);
        step();
        check("R9 low with one left", {7'd0, irq_n}, 8'h00);
        hw(BC, 1'b1, 8'h01);
        step();
        check("R9 released by mask", {7'd0, irq_n}, 8'h01);
        check("R9 flag kept", flags_rd, 8'h01);
        clean();
    endtask

    task automatic t_reserved();
        hw(WR, 1'b0, 8'hFF);
        check("R10 flag reserved", flags_rd, 8'h2B);
        hw(WR, 1'b1, 8'hFF);
        check("R10 enable reserved", enables_rd, 8'hFB);
        clean();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_latch();
        t_link();
        t_pkt();
        t_bitops();
        t_race();
        t_irq();
        t_global();
        t_mask();
        t_reserved();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule